// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block keeps the pending stores of an out-of-order core in program order, from allocation until their bytes have been handed to the memory system. A store takes a slot when it is dispatched. Its address and size arrive later, and so does its data, each through its own write port. A commit pulse marks the oldest store that has not yet committed. Committed stores stay in the buffer and leave one at a time from the head, through a valid/ready write port.

A load presents its address, its size and its age, which is the allocation tag the buffer offered when the load was dispatched. In the same cycle the buffer searches every store older than the load and returns one of three answers. It can forward the bytes from a matching store, report that no older store touches the load's bytes, or tell the load to stall. A flush input drops the speculative, uncommitted stores from a given tag onward and keeps the committed ones.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty. `alloc_full` is 0, `alloc_tag` is 0 and `mem_valid` is 0, and a load gets result 0 (no conflict).
- R2: `alloc_tag` is a 4-bit age made of a 3-bit slot index and a wrap bit. Each accepted allocation advances it by one, modulo 16. `alloc_full` is 1 while 8 stores are held, and an allocation request made while the buffer is full is ignored.
- R3: A load with age A considers only the stores allocated before A was offered. If A lies behind the head, because every store older than it has already drained, no store is considered. Tags compare correctly across the wrap from 15 to 0.
- R4: If any store older than the load has no valid address yet, the result is 2 (stall).
- R5: A load covers the bytes [addr, addr+size) and a store covers [addr, addr+size). If none of the older stores overlaps the load, the result is 0, and ranges that only touch at their ends do not overlap.
- R6: If more than one older store overlaps the load, the youngest of them decides the result. If it covers every byte of the load and its data is valid, the result is 1 (forward). `ld_data` then holds the store data shifted right by 8 times (load address − store address), with the bytes above the load size set to zero.
- R7: If the deciding store covers only part of the load, or its data is not valid yet, the result is 2 (stall).
- R8: Size code 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes. Store data occupies the low bytes of the 64-bit data word. The address and the data of a slot are written once per allocation, and later writes to a field that is already valid are ignored.
- R9: A commit pulse marks the oldest uncommitted store as committed. A pulse is ignored when every held store is already committed.
- R10: `mem_valid` is 1 only when the head store is committed and has both a valid address and valid data. It holds, with the address and data stable, until `mem_ready` is 1. Each handshake removes the head store and frees its slot.
- R11: `flush_req` with boundary tag B removes the uncommitted stores at or after B, and committed stores are always kept. If B lies behind the head, every uncommitted store is removed. An allocation request made in the same cycle as a flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocate a slot for the next store |
| alloc_full | output | 1 | All slots in use |
| alloc_tag | output | 4 | Age tag the next allocation receives |
| addr_we | input | 1 | Write the address and size of a slot |
| addr_slot | input | 3 | Slot index (low bits of the store's tag) |
| addr_val | input | 32 | Store byte address |
| addr_size | input | 2 | Store size code |
| data_we | input | 1 | Write the data of a slot |
| data_slot | input | 3 | Slot index for the data write |
| data_val | input | 64 | Store data, low bytes used |
| commit_req | input | 1 | Commit the oldest uncommitted store |
| flush_req | input | 1 | Remove younger uncommitted stores |
| flush_tag | input | 4 | First tag removed by the flush |
| ld_valid | input | 1 | Load query present |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_age | input | 4 | Load age tag |
| ld_res | output | 2 | 0 no conflict, 1 forward, 2 stall |
| ld_data | output | 64 | Forwarded bytes |
| mem_valid | output | 1 | Head store offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | 32 | Address of the offered store |
| mem_size | output | 2 | Size code of the offered store |
| mem_data | output | 64 | Data of the offered store |

## Verification
The search is driven with a load whose older store has no address yet, and with a load of the same age range that overlaps nothing or only touches a store's end. Further loads sit inside a store, straddle a younger store only in part, or hit a store whose data is missing. These patterns separate the stall, no-conflict and forward answers, and they show that the youngest overlapping store decides. The same address queried with different load ages shows whether only older stores are seen. A second search runs after the tags have wrapped past 15 to check the age comparison at the wrap. Commits, flushes and drains are ordered so that they show committed stores surviving a flush, a commit pulse with nothing left to commit, and the drain port holding its offer while memory is not ready.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FWD   = 2'd1,
        LD_STALL = 2'd2
    } ld_res_e;

    // size code -> number of bytes (1, 2, 4, 8)
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // size code -> mask of the valid low bytes of a data word
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < int'(size_bytes(code))) m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/sb_ptrs.sv
module sb_ptrs #(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned PW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  logic          commit_req,
    input  logic          drain_fire,
    input  logic          flush_req,
    input  logic [PW-1:0] flush_tag,
    output logic [PW-1:0] head,
    output logic [PW-1:0] cmt,
    output logic [PW-1:0] tail,
    output logic [PW-1:0] count,
    output logic          full,
    output logic          alloc_fire
);

    logic          commit_fire;
    logic [PW-1:0] head_n, cmt_n, tail_n;
    logic [PW-1:0] pos_b, pos_c;

    assign count       = tail - head;
    assign full        = (count == PW'(DEPTH));
    assign alloc_fire  = alloc_req && !full && !flush_req;
    assign commit_fire = commit_req && (cmt != tail);

    always_comb begin
        head_n = head + PW'(drain_fire);
        cmt_n  = cmt + PW'(commit_fire);
        pos_b  = flush_tag - head;
        pos_c  = cmt_n - head;
        if (flush_req) begin
            // behind head or inside the committed region: keep only committed
            if (pos_b > count || pos_b < pos_c) tail_n = cmt_n;
            else                                tail_n = flush_tag;
        end else begin
            tail_n = tail + PW'(alloc_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            cmt  <= '0;
            tail <= '0;
        end else begin
            head <= head_n;
            cmt  <= cmt_n;
            tail <= tail_n;
        end
    end

endmodule

// File: rtl/sb_entries.sv
module sb_entries #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned AW    = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned DW    = sb_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_fire,
    input  logic [IW-1:0] alloc_slot,
    input  logic          addr_we,
    input  logic [IW-1:0] addr_slot,
    input  logic [AW-1:0] addr_val,
    input  logic [1:0]    addr_size,
    input  logic          data_we,
    input  logic [IW-1:0] data_slot,
    input  logic [DW-1:0] data_val,
    output logic [AW-1:0] st_addr [DEPTH],
    output logic [1:0]    st_size [DEPTH],
    output logic [DW-1:0] st_data [DEPTH],
    output logic [DEPTH-1:0] st_av,
    output logic [DEPTH-1:0] st_dv
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                st_av[i] <= 1'b0;
                st_dv[i] <= 1'b0;
            end else if (alloc_fire && alloc_slot == IW'(i)) begin
                st_av[i] <= 1'b0;
                st_dv[i] <= 1'b0;
            end else begin
                if (addr_we && addr_slot == IW'(i) && !st_av[i]) begin
                    st_av[i]   <= 1'b1;
                    st_addr[i] <= addr_val;
                    st_size[i] <= addr_size;
                end
                if (data_we && data_slot == IW'(i) && !st_dv[i]) begin
                    st_dv[i]   <= 1'b1;
                    st_data[i] <= data_val;
                end
            end
        end
    end

endmodule

// File: rtl/sb_search.sv
module sb_search #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned AW    = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned PW    = IW + 1,
    localparam int unsigned DW    = sb_pkg::DATA_W,
    localparam int unsigned SW    = sb_pkg::LANE_W,
    localparam int unsigned EW    = AW + 4
) (
    input  logic [PW-1:0]    head,
    input  logic [PW-1:0]    count,
    input  logic [AW-1:0]    st_addr [DEPTH],
    input  logic [1:0]       st_size [DEPTH],
    input  logic [DW-1:0]    st_data [DEPTH],
    input  logic [DEPTH-1:0] st_av,
    input  logic [DEPTH-1:0] st_dv,
    input  logic             ld_valid,
    input  logic [AW-1:0]    ld_addr,
    input  logic [1:0]       ld_size,
    input  logic [PW-1:0]    ld_age,
    output sb_pkg::ld_res_e  ld_res,
    output logic [DW-1:0]    ld_data
);
    import sb_pkg::*;

    logic [DEPTH-1:0] ovl, cov;
    logic [SW-1:0]    shift [DEPTH];
    logic [EW-1:0]    ld_lo, ld_hi;

    // per-entry byte-range compare
    always_comb begin
        ld_lo = EW'(ld_addr);
        ld_hi = ld_lo + EW'(size_bytes(ld_size));
        for (int i = 0; i < DEPTH; i++) begin
            logic [EW-1:0] s_lo, s_hi;
            s_lo     = EW'(st_addr[i]);
            s_hi     = s_lo + EW'(size_bytes(st_size[i]));
            ovl[i]   = (ld_lo < s_hi) && (s_lo < ld_hi);
            cov[i]   = (s_lo <= ld_lo) && (ld_hi <= s_hi);
            shift[i] = ld_addr[SW-1:0] - st_addr[i][SW-1:0];
        end
    end

    logic [PW-1:0] pos_ld, n_older;
    logic          unknown, hit;
    logic [IW-1:0] hit_idx;

    // age-ordered scan from head; the last hit is the youngest
    always_comb begin
        pos_ld  = ld_age - head;
        n_older = (pos_ld > count) ? '0 : pos_ld;
        unknown = 1'b0;
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] idx;
            idx = head[IW-1:0] + IW'(k);
            if (PW'(k) < n_older) begin
                if (!st_av[idx]) begin
                    unknown = 1'b1;
                end else if (ovl[idx]) begin
                    hit     = 1'b1;
                    hit_idx = idx;
                end
            end
        end
    end

    always_comb begin
        ld_data = '0;
        if (!ld_valid)     ld_res = LD_NONE;
        else if (unknown)  ld_res = LD_STALL;
        else if (!hit)     ld_res = LD_NONE;
        else if (cov[hit_idx] && st_dv[hit_idx]) begin
            ld_res  = LD_FWD;
            ld_data = (st_data[hit_idx] >> {shift[hit_idx], 3'b000}) & size_mask(ld_size);
        end else           ld_res = LD_STALL;
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned AW    = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned PW    = IW + 1,
    localparam int unsigned DW    = sb_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    output logic          alloc_full,
    output logic [PW-1:0] alloc_tag,
    input  logic          addr_we,
    input  logic [IW-1:0] addr_slot,
    input  logic [AW-1:0] addr_val,
    input  logic [1:0]    addr_size,
    input  logic          data_we,
    input  logic [IW-1:0] data_slot,
    input  logic [DW-1:0] data_val,
    input  logic          commit_req,
    input  logic          flush_req,
    input  logic [PW-1:0] flush_tag,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    input  logic [PW-1:0] ld_age,
    output logic [1:0]    ld_res,
    output logic [DW-1:0] ld_data,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_data
);

    logic [PW-1:0]    head, cmt, tail, cnt;
    logic             full, alloc_fire, drain_fire;
    logic [AW-1:0]    st_addr [DEPTH];
    logic [1:0]       st_size [DEPTH];
    logic [DW-1:0]    st_data [DEPTH];
    logic [DEPTH-1:0] st_av, st_dv;
    logic [IW-1:0]    head_idx;
    sb_pkg::ld_res_e  res_e;

    assign head_idx   = head[IW-1:0];
    assign alloc_full = full;
    assign alloc_tag  = tail;
    assign mem_valid  = (cmt != head) && st_av[head_idx] && st_dv[head_idx];
    assign drain_fire = mem_valid && mem_ready;
    assign mem_addr   = st_addr[head_idx];
    assign mem_size   = st_size[head_idx];
    assign mem_data   = st_data[head_idx];
    assign ld_res     = res_e;

    sb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_req),
        .commit_req (commit_req),
        .drain_fire (drain_fire),
        .flush_req  (flush_req),
        .flush_tag  (flush_tag),
        .head       (head),
        .cmt        (cmt),
        .tail       (tail),
        .count      (cnt),
        .full       (full),
        .alloc_fire (alloc_fire)
    );

    sb_entries #(.DEPTH(DEPTH), .AW(AW)) u_ent (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_slot (tail[IW-1:0]),
        .addr_we    (addr_we),
        .addr_slot  (addr_slot),
        .addr_val   (addr_val),
        .addr_size  (addr_size),
        .data_we    (data_we),
        .data_slot  (data_slot),
        .data_val   (data_val),
        .st_addr    (st_addr),
        .st_size    (st_size),
        .st_data    (st_data),
        .st_av      (st_av),
        .st_dv      (st_dv)
    );

    sb_search #(.DEPTH(DEPTH), .AW(AW)) u_srch (
        .head     (head),
        .count    (cnt),
        .st_addr  (st_addr),
        .st_size  (st_size),
        .st_data  (st_data),
        .st_av    (st_av),
        .st_dv    (st_dv),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_size  (ld_size),
        .ld_age   (ld_age),
        .ld_res   (res_e),
        .ld_data  (ld_data)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned AW    = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned PW    = IW + 1,
    localparam int unsigned DW    = sb_pkg::DATA_W
) (
    input logic          clk,
    input logic          rst,
    input logic          alloc_req,
    input logic          flush_req,
    input logic          alloc_full,
    input logic [PW-1:0] alloc_tag,
    input logic [PW-1:0] head,
    input logic [PW-1:0] cmt,
    input logic [PW-1:0] cnt,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [1:0]    ld_res
);

    p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_req && alloc_full && !flush_req |=> $stable(alloc_tag));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= PW'(DEPTH));

    p_commit_window_r9: assert property (@(posedge clk) disable iff (rst)
        PW'(cmt - head) <= cnt);

    p_drain_hold_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    p_drain_committed_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> cmt != head);

    p_result_code_r6: assert property (@(posedge clk) disable iff (rst)
        ld_res != 2'b11);

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW)) u_sb_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_req  (alloc_req),
    .flush_req  (flush_req),
    .alloc_full (alloc_full),
    .alloc_tag  (alloc_tag),
    .head       (head),
    .cmt        (cmt),
    .cnt        (cnt),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .ld_res     (ld_res)
);

// File: tb/tb_store_buffer.sv
module tb_store_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_req = 0, addr_we = 0, data_we = 0, commit_req = 0, flush_req = 0;
    logic        ld_valid = 0, mem_ready = 0;
    logic        alloc_full, mem_valid;
    logic [3:0]  alloc_tag, flush_tag = 0, ld_age = 0;
    logic [2:0]  addr_slot = 0, data_slot = 0;
    logic [31:0] addr_val = 0, ld_addr = 0, mem_addr;
    logic [1:0]  addr_size = 0, ld_size = 0, ld_res, mem_size;
    logic [63:0] data_val = 0, ld_data, mem_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] q_addr [$];
    logic [1:0]  q_size [$];
    logic [63:0] q_data [$];

    always #4 clk = ~clk;

    store_buffer dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each memory handshake
    always @(negedge clk) begin
        #2;
        if (!rst && mem_valid && mem_ready) begin
            if (q_addr.size() == 0) chk(0, "R10 unexpected drain", {32'd0, mem_addr}, 64'd0);
            else begin
                logic [31:0] ea; logic [1:0] es; logic [63:0] ed;
                ea = q_addr.pop_front(); es = q_size.pop_front(); ed = q_data.pop_front();
                chk(mem_addr == ea && mem_size == es && mem_data == ed, "R10 drain order",
                    mem_data, ed);
            end
        end
    end

    task automatic alloc(output logic [3:0] tag);
        @(negedge clk); tag = alloc_tag; alloc_req = 1;
        @(negedge clk); alloc_req = 0;
    endtask

    task automatic fill(input logic [2:0] s, input logic [31:0] a, input logic [1:0] sz,
                        input bit wd, input logic [63:0] d);
        @(negedge clk);
        addr_we = 1; addr_slot = s; addr_val = a; addr_size = sz;
        data_we = wd; data_slot = s; data_val = d;
        @(negedge clk); addr_we = 0; data_we = 0;
    endtask

    // driver: pushes the expected memory write when a commit should take effect
    task automatic commit(input bit push, input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk); commit_req = 1;
        if (push) begin q_addr.push_back(a); q_size.push_back(sz); q_data.push_back(d); end
        @(negedge clk); commit_req = 0;
    endtask

    task automatic flush(input logic [3:0] b, input bit with_alloc);
        @(negedge clk); flush_req = 1; flush_tag = b; alloc_req = with_alloc;
        @(negedge clk); flush_req = 0; alloc_req = 0;
    endtask

    task automatic ld_chk(input logic [3:0] age, input logic [31:0] a, input logic [1:0] sz,
                          input logic [1:0] er, input logic [63:0] ed, input string req);
        @(negedge clk); ld_valid = 1; ld_age = age; ld_addr = a; ld_size = sz;
        #1;
        chk(ld_res == er, req, {62'd0, ld_res}, {62'd0, er});
        if (er == 2'd1) chk(ld_data == ed, req, ld_data, ed);
        ld_valid = 0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 60 && q_addr.size() != 0; i++) @(negedge clk);
        @(negedge clk); @(negedge clk);
        chk(q_addr.size() == 0, "R10 all drained", 64'(q_addr.size()), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [3:0] t;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        #1;
        chk(!alloc_full && alloc_tag == 0 && !mem_valid, "R1 reset", {alloc_full, alloc_tag, mem_valid}, 0);
        ld_chk(4'd0, 32'h100, 2'd3, 2'd0, 0, "R1 empty load");

        // R2 sequential tags
        alloc(t); chk(t == 0, "R2 tag0", t, 0);
        alloc(t); chk(t == 1, "R2 tag1", t, 1);
        alloc(t); chk(t == 2, "R2 tag2", t, 2);
        ld_chk(4'd3, 32'h300, 2'd0, 2'd2, 0, "R4 unknown older address");
        ld_chk(4'd0, 32'h300, 2'd0, 2'd0, 0, "R3 no older stores");

        fill(3'd0, 32'h100, 2'd3, 1, 64'h1122334455667788);
        fill(3'd1, 32'h104, 2'd1, 1, 64'h000000000000AABB);
        fill(3'd2, 32'h200, 2'd2, 0, 0);
        fill(3'd0, 32'h900, 2'd0, 1, 64'hFF); // R8 second write ignored

        ld_chk(4'd3, 32'h300, 2'd2, 2'd0, 0, "R5 no overlap");
        ld_chk(4'd3, 32'h1FE, 2'd1, 2'd0, 0, "R5 touching ends");
        ld_chk(4'd3, 32'h102, 2'd1, 2'd1, 64'h5566, "R6 R8 offset forward");
        ld_chk(4'd3, 32'h104, 2'd1, 2'd1, 64'hAABB, "R6 youngest wins");
        ld_chk(4'd1, 32'h104, 2'd1, 2'd1, 64'h3344, "R3 younger store ignored");
        ld_chk(4'd3, 32'h103, 2'd2, 2'd2, 0, "R7 partial cover");
        ld_chk(4'd3, 32'h200, 2'd0, 2'd2, 0, "R7 data invalid");

        fill(3'd2, 32'h0, 2'd0, 1, 64'hDEADBEEF);
        ld_chk(4'd3, 32'h201, 2'd0, 2'd1, 64'hBE, "R6 byte forward");

        commit(1, 32'h100, 2'd3, 64'h1122334455667788);
        commit(1, 32'h104, 2'd1, 64'h000000000000AABB);
        flush(4'd2, 0);
        #1; chk(alloc_tag == 2, "R11 uncommitted removed", alloc_tag, 2);
        ld_chk(4'd2, 32'h104, 2'd1, 2'd1, 64'hAABB, "R11 committed still searched");
        flush(4'd0, 0);
        #1; chk(alloc_tag == 2, "R11 committed kept", alloc_tag, 2);

        @(negedge clk); #1;
        chk(mem_valid && mem_addr == 32'h100, "R10 offer", {31'd0, mem_valid, mem_addr}, {31'd0, 1'b1, 32'h100});
        @(negedge clk); #1;
        chk(mem_valid && mem_addr == 32'h100, "R10 hold", {31'd0, mem_valid, mem_addr}, {31'd0, 1'b1, 32'h100});
        mem_ready = 1;
        wait_drain();
        #1; chk(!mem_valid && !alloc_full, "R10 empty after drain", {mem_valid, alloc_full}, 0);

        // R9 commit with nothing uncommitted is ignored
        commit(0, 0, 0, 0);
        alloc(t); chk(t == 2, "R2 tag after drain", t, 2);
        fill(3'd2, 32'h300, 2'd3, 1, 64'hCAFE);
        repeat (3) @(negedge clk); #1;
        chk(!mem_valid, "R9 stray commit ignored", mem_valid, 0);
        commit(1, 32'h300, 2'd3, 64'hCAFE);
        wait_drain();

        // R2 full, R11 flush all with simultaneous alloc
        for (int i = 0; i < 8; i++) begin
            alloc(t); chk(t == 4'(3 + i), "R2 fill tags", t, 4'(3 + i));
        end
        #1; chk(alloc_full, "R2 full", alloc_full, 1);
        alloc(t); #1; chk(alloc_tag == 11, "R2 alloc when full ignored", alloc_tag, 11);
        ld_chk(4'd11, 32'h0, 2'd0, 2'd2, 0, "R4 all addresses unknown");
        flush(4'd3, 1);
        #1; chk(alloc_tag == 3 && !alloc_full, "R11 flush all, alloc ignored", alloc_tag, 3);

        // advance head toward the wrap
        for (int i = 0; i < 8; i++) begin
            alloc(t);
            fill(t[2:0], 32'h1000 + 32'(i * 16), 2'd3, 1, 64'(i));
        end
        for (int i = 0; i < 8; i++) commit(1, 32'h1000 + 32'(i * 16), 2'd3, 64'(i));
        wait_drain();

        for (int i = 0; i < 6; i++) alloc(t);
        #1; chk(alloc_tag == 1, "R2 tag wrap", alloc_tag, 1);
        for (int i = 0; i < 4; i++) fill(3'(3 + i), 32'h600 + 32'(i * 16), 2'd3, 1, 0);
        fill(3'd7, 32'h400, 2'd3, 1, 64'h0123456789ABCDEF);
        ld_chk(4'd0, 32'h404, 2'd2, 2'd1, 64'h01234567, "R3 age across wrap");
        ld_chk(4'd1, 32'h404, 2'd2, 2'd2, 0, "R3 R4 wrapped tag0 unknown");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule